// File: doc/BRIEF.md
# SRAM Readback Access Controller

This block sits between a request port and a single-port synchronous SRAM. Each request is a read or a write with a per-byte write mask. A full-word access takes one memory cycle. A write with some mask bits clear is done in three steps: the controller reads the old word, merges in the enabled bytes, then writes the result back. The memory returns read data one cycle after a read command.

A 4-bit readback setting turns on a checking mode. In this mode every access is followed by a second read of the same word. For a read, the re-read data is compared with the first data. For a write, it is compared with the word that was written. A mismatch raises a one-cycle alert and sets an error flag that stays set until reset. The access itself still completes normally on the request port. A write is acknowledged before its check finishes. The setting can be changed while traffic is flowing, and each request uses the value in force when it is accepted.

After reset the controller fills every word with zero, one word per cycle. No request is granted until this fill is finished.

Top module: `sram_rb_ctrl`

## Requirements
- R1: With readback off and full-word masks, a request is accepted every cycle and its response (rsp_valid_o) appears in the cycle after acceptance, so N back-to-back accesses span N+1 cycles.
- R2: A read response carries the word most recently written to that address (after any byte merge), on rsp_rdata_o in the response cycle.
- R3: A write whose mask (bit i enables bits 8i+7:8i) is not all ones keeps the bytes with clear mask bits. It is acknowledged 3 cycles after acceptance, and req_ready_o is low for the 2 cycles after acceptance, so it costs 2 extra cycles.
- R4: With readback on, a read is answered in the cycle after acceptance, and the next request can be accepted 2 cycles after acceptance.
- R5: With readback on, a full write is acknowledged in the cycle after acceptance, before its check ends. The next request can be accepted 3 cycles after acceptance.
- R6: With readback on, a masked write does the read-merge-write sequence, then one re-read and compare of the merged word. It is acknowledged 3 cycles after acceptance, and the next request can be accepted 5 cycles after acceptance.
- R7: The readback setting is 4'h9 for off and 4'h6 for on. Any other value counts as on. It resets to off. A write to it applies to requests accepted from the next cycle onward.
- R8: A readback mismatch drives rb_alert_o high for one cycle. That cycle is the one after the compare cycle: acceptance+3 for reads and full writes, acceptance+5 for masked writes. rb_err_o rises in the same cycle and stays high until reset. The access is still acknowledged.
- R9: After reset, the controller writes zero to each of the 2^AW words in turn during cycles 0 to 2^AW-1, and req_ready_o stays low. init_done_o goes high in cycle 2^AW and stays high. Words not yet written read back as zero.
- R10: In the first cycle after reset, req_ready_o, rsp_valid_o, rb_alert_o, rb_err_o and init_done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_mask_i | input | DW/8 | Byte enables for writes |
| rsp_valid_o | output | 1 | Read data or write acknowledge |
| rsp_rdata_o | output | DW | Read data, valid with a read response |
| rb_cfg_we_i | input | 1 | Load the readback setting |
| rb_cfg_i | input | 4 | New readback setting |
| mem_req_o | output | 1 | Memory command |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after a read |
| init_done_o | output | 1 | Zero fill finished |
| rb_err_o | output | 1 | Sticky readback mismatch |
| rb_alert_o | output | 1 | Readback mismatch pulse |

## Verification
A sequencer stuck in a busy state shows up as req_ready_o low in the very next cycle the reference expects a grant. A sequencer that skips a state shows up as an early grant or an early acknowledge within one to five cycles of the affected request. A wrong merge register or stale captured address shows up as wrong read data on the next read of that word. A compare stage that holds the wrong expected word raises an alert three or five cycles after acceptance, on a memory that has no fault. A memory model with one stuck bit makes the real mismatch path, and the sticky flag, visible at the ports.

// File: rtl/sram_rb_pkg.sv
package sram_rb_pkg;

    localparam logic [3:0] RB_CFG_ON  = 4'h6;
    localparam logic [3:0] RB_CFG_OFF = 4'h9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MERGE,
        ST_WRITE,
        ST_REREAD,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic is_write;
        logic rb_on;
    } op_info_t;

    // Only the exact "off" code disables checking; corrupted codes fail safe.
    function automatic logic rb_decode(input logic [3:0] code);
        if (code == RB_CFG_ON)  return 1'b1;
        if (code == RB_CFG_OFF) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sram_rb_cfg.sv
module sram_rb_cfg
    import sram_rb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       cfg_we_i,
    input  logic [3:0] cfg_i,
    output logic       rb_en_o
);
    logic [3:0] code_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= RB_CFG_OFF;
        end else if (cfg_we_i) begin
            code_q <= cfg_i;
        end
    end

    assign rb_en_o = rb_decode(code_q);
endmodule

// File: rtl/sram_rb_init.sv
module sram_rb_init #(
    parameter int AW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic          active_o,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    logic [AW-1:0] cnt_q;
    logic          active_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) begin
                active_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
    assign addr_o   = cnt_q;
    assign done_o   = !active_q;
endmodule

// File: rtl/sram_rb_compare.sv
module sram_rb_compare #(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          chk_valid_i,
    input  logic [DW-1:0] chk_exp_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          alert_o,
    output logic          err_o
);
    logic mismatch;
    logic alert_q, err_q;

    assign mismatch = chk_valid_i && (mem_rdata_i != chk_exp_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            alert_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            alert_q <= mismatch;
            err_q   <= err_q | mismatch;
        end
    end

    assign alert_o = alert_q;
    assign err_o   = err_q;
endmodule

// File: rtl/sram_rb_seq.sv
module sram_rb_seq
    import sram_rb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          init_done_i,
    input  logic          rb_en_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [BW-1:0] req_mask_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          cmd_req_o,
    output logic          cmd_we_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [DW-1:0] cmd_wdata_o,
    output logic          rsp_valid_o,
    output logic          rsp_read_o,
    output logic          chk_valid_o,
    output logic [DW-1:0] chk_exp_o
);
    seq_state_e    state_q, state_d;
    op_info_t      info_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [BW-1:0] mask_q;
    logic          rsp_valid_q, rsp_read_q, chk_valid_q;
    logic [DW-1:0] chk_exp_q;
    logic [DW-1:0] merged;
    logic          accept, masked_wr;

    for (genvar b = 0; b < BW; b++) begin : g_merge
        assign merged[b*8 +: 8] = mask_q[b] ? data_q[b*8 +: 8] : mem_rdata_i[b*8 +: 8];
    end

    assign req_ready_o = init_done_i && (state_q == ST_IDLE);
    assign accept      = req_valid_i && req_ready_o;
    assign masked_wr   = req_we_i && !(&req_mask_i);

    always_comb begin
        state_d     = state_q;
        cmd_req_o   = 1'b0;
        cmd_we_o    = 1'b0;
        cmd_addr_o  = addr_q;
        cmd_wdata_o = data_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    cmd_req_o   = 1'b1;
                    cmd_we_o    = req_we_i && !masked_wr;
                    cmd_addr_o  = req_addr_i;
                    cmd_wdata_o = req_wdata_i;
                    if (masked_wr)    state_d = ST_MERGE;
                    else if (rb_en_i) state_d = ST_REREAD;
                end
            end
            ST_MERGE: state_d = ST_WRITE;
            ST_WRITE: begin
                cmd_req_o = 1'b1;
                cmd_we_o  = 1'b1;
                state_d   = info_q.rb_on ? ST_REREAD : ST_IDLE;
            end
            ST_REREAD: begin
                cmd_req_o = 1'b1;
                state_d   = info_q.is_write ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_IDLE;
            info_q      <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            mask_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_read_q  <= 1'b0;
            chk_valid_q <= 1'b0;
            chk_exp_q   <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= (accept && !masked_wr) || (state_q == ST_WRITE);
            rsp_read_q  <= accept && !req_we_i;
            chk_valid_q <= (state_q == ST_REREAD);
            if (state_q == ST_REREAD) begin
                chk_exp_q <= info_q.is_write ? data_q : mem_rdata_i;
            end
            if (accept) begin
                info_q <= '{is_write: req_we_i, rb_on: rb_en_i};
                addr_q <= req_addr_i;
                data_q <= req_wdata_i;
                mask_q <= req_mask_i;
            end else if (state_q == ST_MERGE) begin
                data_q <= merged;
            end
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_read_o  = rsp_read_q;
    assign chk_valid_o = chk_valid_q;
    assign chk_exp_o   = chk_exp_q;
endmodule

// File: rtl/sram_rb_ctrl.sv
module sram_rb_ctrl #(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [BW-1:0] req_mask_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o,
    input  logic          rb_cfg_we_i,
    input  logic [3:0]    rb_cfg_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          init_done_o,
    output logic          rb_err_o,
    output logic          rb_alert_o
);
    logic          rb_en;
    logic          init_active, init_done;
    logic [AW-1:0] init_addr;
    logic          cmd_req, cmd_we;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic          rsp_read, chk_valid;
    logic [DW-1:0] chk_exp;

    sram_rb_cfg u_cfg (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cfg_we_i (rb_cfg_we_i),
        .cfg_i    (rb_cfg_i),
        .rb_en_o  (rb_en)
    );

    sram_rb_init #(.AW(AW)) u_init (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_o (init_active),
        .addr_o   (init_addr),
        .done_o   (init_done)
    );

    sram_rb_seq #(.AW(AW), .DW(DW), .BW(BW)) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .init_done_i (init_done),
        .rb_en_i     (rb_en),
        .req_valid_i (req_valid_i),
        .req_ready_o (req_ready_o),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .req_mask_i  (req_mask_i),
        .mem_rdata_i (mem_rdata_i),
        .cmd_req_o   (cmd_req),
        .cmd_we_o    (cmd_we),
        .cmd_addr_o  (cmd_addr),
        .cmd_wdata_o (cmd_wdata),
        .rsp_valid_o (rsp_valid_o),
        .rsp_read_o  (rsp_read),
        .chk_valid_o (chk_valid),
        .chk_exp_o   (chk_exp)
    );

    sram_rb_compare #(.DW(DW)) u_cmp (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .chk_valid_i (chk_valid),
        .chk_exp_i   (chk_exp),
        .mem_rdata_i (mem_rdata_i),
        .alert_o     (rb_alert_o),
        .err_o       (rb_err_o)
    );

    assign mem_req_o   = init_active | cmd_req;
    assign mem_we_o    = init_active | cmd_we;
    assign mem_addr_o  = init_active ? init_addr : cmd_addr;
    assign mem_wdata_o = init_active ? '0 : cmd_wdata;
    assign rsp_rdata_o = (rsp_valid_o && rsp_read) ? mem_rdata_i : '0;
    assign init_done_o = init_done;
endmodule

// File: rtl/sram_rb_ctrl_chk.sv
module sram_rb_ctrl_chk #(
    parameter int BW = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          req_valid_i,
    input logic          req_ready_o,
    input logic          req_we_i,
    input logic [BW-1:0] req_mask_i,
    input logic          rsp_valid_o,
    input logic          init_done_o,
    input logic          rb_err_o,
    input logic          rb_alert_o,
    input logic          rb_en_i
);
    logic acc;
    assign acc = req_valid_i && req_ready_o;

    AST_READ_RSP_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        acc && !req_we_i |=> rsp_valid_o); // R1

    AST_MASKED_ACK_LATE: assert property (@(posedge clk_i) disable iff (rst_i)
        acc && req_we_i && !(&req_mask_i) |=> !rsp_valid_o ##1 !rsp_valid_o ##1 rsp_valid_o); // R3

    AST_RB_READ_COST: assert property (@(posedge clk_i) disable iff (rst_i)
        acc && !req_we_i && rb_en_i |=> !req_ready_o ##1 req_ready_o); // R4

    AST_RB_WRITE_COST: assert property (@(posedge clk_i) disable iff (rst_i)
        acc && req_we_i && (&req_mask_i) && rb_en_i |=> rsp_valid_o && !req_ready_o ##1 !req_ready_o ##1 req_ready_o); // R5

    AST_ALERT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        rb_alert_o |=> !rb_alert_o); // R8

    AST_ALERT_WITH_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        rb_alert_o |-> rb_err_o); // R8

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        rb_err_o |=> rb_err_o); // R8

    AST_INIT_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        !init_done_o |-> !req_ready_o); // R9

    AST_INIT_DONE_STAYS: assert property (@(posedge clk_i) disable iff (rst_i)
        init_done_o |=> init_done_o); // R9
endmodule

bind sram_rb_ctrl sram_rb_ctrl_chk #(.BW(BW)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_we_i    (req_we_i),
    .req_mask_i  (req_mask_i),
    .rsp_valid_o (rsp_valid_o),
    .init_done_o (init_done_o),
    .rb_err_o    (rb_err_o),
    .rb_alert_o  (rb_alert_o),
    .rb_en_i     (rb_en)
);

// File: tb/sram_rb_ctrl_tb_top.sv
module sram_rb_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] STUCK_A = 4'd10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_mask = '1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_val = 4'h9;
    logic          req_ready, rsp_valid, init_done, rb_err, rb_alert;
    logic [DW-1:0] rsp_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem [DEPTH];
    logic          fill = 1'b1;
    logic          stuck_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_rb_ctrl #(.AW(AW), .DW(DW)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .rb_cfg_we_i(cfg_we), .rb_cfg_i(cfg_val),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .init_done_o(init_done), .rb_err_o(rb_err), .rb_alert_o(rb_alert)
    );

    // Behavioural single-port memory, one-cycle read latency, optional stuck bit 0.
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 32'hA5A5_0000 | i;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= (stuck_en && mem_addr == STUCK_A) ? (mem_wdata | 1) : mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // Reference model state
    int            n_chk = 0, n_err = 0;
    int            cyc = 0;
    int            next_free = 0;
    int            err_from = -1;
    int            last_rsp_obs = -1;
    int            burst_first = -1;
    int            b_w, b_r, b_p, b_lastw;
    bit            accepted;
    bit            done_flag = 0;
    logic [3:0]    cfg_model = 4'h9;
    logic [DW-1:0] shadow [DEPTH];
    logic [DW:0]   exp_rsp [int];
    string         exp_tag [int];
    bit            exp_alert [int];
    string         last_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_w,
            input logic [DW-1:0] new_w, input logic [BW-1:0] m);
        logic [DW-1:0] r = old_w;
        for (int b = 0; b < BW; b++) if (m[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    task automatic model_accept(input int c);
        bit rb, full;
        int cost, d, a;
        string tag;
        logic [DW-1:0] mg, st;
        accepted = 0;
        if (req_valid && c >= DEPTH && c >= next_free) begin
            accepted = 1;
            if (burst_first < 0) burst_first = c;
            rb   = (cfg_model != 4'h9);
            full = &req_mask;
            if (req_we && !full)                       tag = rb ? "R6" : "R3";
            else if (cfg_model != 4'h9 && cfg_model != 4'h6) tag = "R7";
            else if (rb)                               tag = req_we ? "R5" : "R4";
            else                                       tag = "R1";
            if (!req_we) begin
                exp_rsp[c+1] = {1'b1, shadow[req_addr]};
                exp_tag[c+1] = tag;
                cost = rb ? 2 : 1;
            end else begin
                mg = merge_bytes(shadow[req_addr], req_wdata, req_mask);
                st = (stuck_en && req_addr == STUCK_A) ? (mg | 1) : mg;
                shadow[req_addr] = st;
                d = full ? 1 : 3;
                exp_rsp[c+d] = '0;
                exp_tag[c+d] = tag;
                cost = full ? (rb ? 3 : 1) : (rb ? 5 : 3);
                if (rb && st != mg) begin
                    a = c + (full ? 3 : 5);
                    exp_alert[a] = 1;
                    if (err_from < 0) err_from = a;
                end
            end
            next_free = c + cost;
            last_tag = tag;
        end
        if (cfg_we) cfg_model = cfg_val;
    endtask

    task automatic model_compare(input int c);
        bit er, eready, eerr;
        eready = (c >= DEPTH) && (c >= next_free);
        chk(req_ready == eready, (c < DEPTH) ? "R9" : last_tag, "req_ready", req_ready, eready);
        chk(init_done == (c >= DEPTH), "R9", "init_done", init_done, c >= DEPTH);
        er = exp_rsp.exists(c);
        chk(rsp_valid == er, er ? exp_tag[c] : last_tag, "rsp_valid", rsp_valid, er);
        if (er && rsp_valid && exp_rsp[c][DW])
            chk(rsp_rdata == exp_rsp[c][DW-1:0], "R2", "rsp_rdata", rsp_rdata, exp_rsp[c][DW-1:0]);
        if (rsp_valid) last_rsp_obs = c;
        chk(rb_alert == exp_alert.exists(c), "R8", "rb_alert", rb_alert, exp_alert.exists(c));
        eerr = (err_from >= 0) && (c >= err_from);
        chk(rb_err == eerr, "R8", "rb_err", rb_err, eerr);
    endtask

    task automatic step();
        model_accept(cyc);
        @(negedge clk);
        cyc++;
        model_compare(cyc);
    endtask

    task automatic do_op(input bit we, input int addr, input logic [DW-1:0] data,
                         input logic [BW-1:0] m);
        req_valid = 1; req_we = we; req_addr = AW'(addr); req_wdata = data; req_mask = m;
        do step(); while (!accepted);
        req_valid = 0;
        if (we) begin b_w++; if (!(&m)) b_p++; b_lastw = 1; end
        else begin b_r++; b_lastw = 0; end
    endtask

    task automatic set_cfg(input logic [3:0] v);
        cfg_we = 1; cfg_val = v;
        step();
        cfg_we = 0;
    endtask

    task automatic burst_begin();
        burst_first = -1; b_w = 0; b_r = 0; b_p = 0; b_lastw = 0;
    endtask

    task automatic burst_end(input bit rb, input string tag);
        int exp_span;
        repeat (8) step();
        exp_span = rb ? (3*b_w + 2*b_r - b_lastw) : (b_w + b_r + 1 + 2*b_p);
        chk(last_rsp_obs - burst_first + 1 == exp_span, tag, "burst span",
            DW'(last_rsp_obs - burst_first + 1), DW'(exp_span));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        fill = 0; rst = 0; cyc = 0;
        // R10: outputs right after reset
        chk(!req_ready && !rsp_valid && !rb_alert && !rb_err && !init_done, "R10",
            "reset outputs", {27'd0, req_ready, rsp_valid, rb_alert, rb_err, init_done}, '0);
        model_compare(0);

        // R9: request raised during the fill is held off, then reads zero
        do_op(0, 3, '0, '1);
        do_op(0, 5, '0, '1);
        repeat (3) step();

        // R1: full-word traffic, readback off
        burst_begin();
        for (int i = 0; i < 4; i++) do_op(1, i, 32'h1000_0001 * (i + 1), '1);
        for (int i = 0; i < 4; i++) do_op(0, i, '0, '1);
        burst_end(0, "R1");

        // R3: masked writes, readback off
        burst_begin();
        do_op(1, 1, 32'hCAFE_BABE, 4'b0011);
        do_op(0, 1, '0, '1);
        do_op(1, 2, 32'h7700_0000, 4'b1000);
        do_op(0, 2, '0, '1);
        burst_end(0, "R3");

        // R4, R5: readback on with the true code
        set_cfg(4'h6);
        burst_begin();
        do_op(1, 4, 32'h4444_4444, '1);
        do_op(0, 4, '0, '1);
        do_op(1, 5, 32'h5555_5554, '1);
        do_op(0, 5, '0, '1);
        burst_end(1, "R4");
        burst_begin();
        do_op(0, 0, '0, '1);
        do_op(1, 6, 32'h6666_0006, '1);
        burst_end(1, "R5");

        // R6: masked write with readback
        do_op(1, 4, 32'h00AB_CD00, 4'b0110);
        do_op(0, 4, '0, '1);
        repeat (6) step();

        // R7: other codes count as on; the off code turns checking off
        set_cfg(4'h3);
        burst_begin();
        do_op(1, 8, 32'h8888_0008, '1);
        do_op(0, 8, '0, '1);
        burst_end(1, "R7");
        set_cfg(4'h0);
        burst_begin();
        do_op(0, 8, '0, '1);
        burst_end(1, "R7");
        set_cfg(4'h9);
        burst_begin();
        do_op(1, 9, 32'h9999_0009, '1);
        do_op(0, 9, '0, '1);
        burst_end(0, "R7");

        // R8: stuck bit in the memory model
        stuck_en = 1;
        step();
        do_op(1, 10, 32'h0000_0A0A, '1);   // readback off: no alert
        do_op(0, 10, '0, '1);
        repeat (4) step();
        set_cfg(4'h6);
        do_op(1, 10, 32'h1234_5678, '1);   // mismatch, alert at +3
        repeat (6) step();
        do_op(1, 10, 32'h1234_5679, '1);   // odd value: no mismatch
        repeat (4) step();
        do_op(1, 10, 32'h0000_0020, 4'b0001); // masked, mismatch, alert at +5
        repeat (8) step();
        do_op(0, 10, '0, '1);
        repeat (4) step();
        stuck_en = 0;
        set_cfg(4'h9);
        do_op(1, 11, 32'hBBBB_000B, '1);
        do_op(0, 11, '0, '1);
        repeat (6) step();

        finish_run();
    end
endmodule